// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the digital half of a programmable feedback divider placed after a dual-modulus P/P+1 prescaler. It is clocked by the prescaler output. It drives the prescaler's modulus control and produces one feedback pulse for every N cycles of the prescaler's input, where N = B·P + A. A frame lasts B prescaler-output cycles. For the first A of them the modulus control asks for P+1 (the swallow phase). For the remaining B − A it asks for P.

The programmed swallow count A, main count B and modulus select are sampled only at a frame boundary and then held for a whole frame. A configuration with A ≥ B, or with B below the minimum main count, is made legal before use and reported on a flag. A second flag reports when the effective ratio falls below P² − P. Below that value, consecutive integer ratios cannot all be reached with the selected prescaler.

Top module: `pulse_swallow_div`

## Requirements
- R1: The number of prescaler-input cycles between consecutive feedback pulses equals effB·P + effA. Here P is 8, 16 or 32 for the latched modulus code, and effA and effB are the effective counts defined in R6 and R7.
- R2: `fbPulse` is high for exactly one cycle, on the last prescaler-output cycle of each frame. A frame lasts effB prescaler-output cycles.
- R3: `modCtrl` (1 = divide by P+1) is high on the first effA cycles of each frame. It is low on the remaining cycles, including the feedback-pulse cycle.
- R4: Modulus select encoding is 0 → 8/9, 1 → 16/17, 2 → 32/33, and code 3 is treated as 32/33. `modSel` outputs the latched, normalised code (never 3).
- R5: Values on `swallowIn`, `mainIn` and `presSel` are sampled only on the clock edge that follows a feedback pulse, or on the first edge after reset. Changes made within a frame have no effect on that frame.
- R6: If the swallow value is at least the effective main count, the frame runs with effA = effB − 1 and `cfgIllegal` is high for that frame.
- R7: A main value below 3 is run as effB = 3 and `cfgIllegal` is high for that frame. Otherwise effB is the main value, and effA is the swallow value unless R6 applies.
- R8: `ratioLow` is high for a frame exactly when effB·P + effA < P² − P (56, 240 or 992).
- R9: While reset is asserted, all outputs are 0. The first rising edge after release loads the configuration. The cycle before that edge has no feedback pulse and no modulus request.
- R10: With a swallow value of 0, `modCtrl` stays low for the whole frame and the ratio is effB·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| presSel | input | 2 | Prescaler modulus select code |
| swallowIn | input | 5 | Programmed swallow count A |
| mainIn | input | 13 | Programmed main count B |
| modCtrl | output | 1 | Modulus control to prescaler, 1 = P+1 |
| fbPulse | output | 1 | One-cycle feedback pulse per frame |
| modSel | output | 2 | Latched, normalised modulus code for the prescaler |
| cfgIllegal | output | 1 | Current frame runs a corrected configuration |
| ratioLow | output | 1 | Current ratio is below P² − P |

## Verification
A behavioural prescaler in the bench adds P or P+1 input cycles for every output cycle, depending on `modCtrl`. Each frame's cycle count, swallow count and total ratio are compared against the configuration the bench expects was latched at that frame's start.

Directed frames cover these cases:
- a zero swallow count, which separates a pure divide-by-P frame from an off-by-one swallow phase;
- A equal to B, and a main value below three, which separate the two correction paths;
- a ratio under P² − P, which tests the low-ratio flag;
- the reserved select code;
- the largest main count, which exercises the full counter width.

Random configurations are then changed at random points inside frames. A design that picked up new values mid-frame would give a frame length or ratio that differs from the latched configuration.

// File: rtl/psw_pkg.sv
package psw_pkg;

  // Modulus select codes as seen by the prescaler
  typedef enum logic [1:0] {
    MOD_8_9   = 2'd0,
    MOD_16_17 = 2'd1,
    MOD_32_33 = 2'd2
  } modSel_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;
    logic decA;
    logic decB;
  } ctlStrobe_t;

  // Fold the reserved code onto the largest modulus
  function automatic logic [1:0] normSel(input logic [1:0] sel);
    return (sel == 2'd3) ? MOD_32_33 : sel;
  endfunction

endpackage

// File: rtl/psw_cfg.sv
// Configuration sanitiser: clamps B, corrects A, computes ratio check.
module psw_cfg #(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int B_MIN = 3
) (
  input  logic [1:0]     selIn,
  input  logic [A_W-1:0] aIn,
  input  logic [B_W-1:0] bIn,
  output logic [1:0]     selEff,
  output logic [A_W-1:0] aEff,
  output logic [B_W-1:0] bEff,
  output logic           illegal,
  output logic           low
);
  import psw_pkg::*;

  localparam int N_W = B_W + A_W + 2;

  logic           bSmall;
  logic           aOver;
  logic [N_W-1:0] pVal;
  logic [N_W-1:0] nVal;
  logic [N_W-1:0] minN;

  always_comb begin
    bSmall  = (bIn < B_W'(B_MIN));
    bEff    = bSmall ? B_W'(B_MIN) : bIn;
    aOver   = (B_W'(aIn) >= bEff);
    aEff    = aOver ? A_W'(bEff - 1'b1) : aIn;
    illegal = bSmall | aOver;
    selEff  = normSel(selIn);
    pVal    = N_W'(8) << selEff;
    nVal    = (N_W'(bEff) << (3 + selEff)) + N_W'(aEff);
    minN    = (pVal * pVal) - pVal;
    low     = (nVal < minN);
  end

endmodule

// File: rtl/psw_ctrl.sv
// Control: decides reload and countdown strobes each prescaler cycle.
module psw_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 aZero,
  input  logic                 bZero,
  output psw_pkg::ctlStrobe_t  strobe,
  output logic                 fbPulse
);
  logic started;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  always_comb begin
    strobe.load = !started || bZero;
    strobe.decB = started && !bZero;
    strobe.decA = started && !bZero && !aZero;
    fbPulse     = started && bZero;
  end

endmodule

// File: rtl/psw_datapath.sv
// Datapath: swallow and main down-counters plus frame shadow registers.
module psw_datapath #(
  parameter int A_W = 5,
  parameter int B_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  psw_pkg::ctlStrobe_t strobe,
  input  logic [1:0]          selEff,
  input  logic [A_W-1:0]      aEff,
  input  logic [B_W-1:0]      bEff,
  input  logic                illegal,
  input  logic                low,
  output logic                aZero,
  output logic                bZero,
  output logic                modCtrl,
  output logic [1:0]          modSel,
  output logic                cfgIllegal,
  output logic                ratioLow
);
  logic [A_W-1:0] aCnt;
  logic [B_W-1:0] bCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aCnt <= '0;
      bCnt <= '0;
    end else if (strobe.load) begin
      aCnt <= aEff;
      bCnt <= bEff - 1'b1;
    end else begin
      if (strobe.decA) aCnt <= aCnt - 1'b1;
      if (strobe.decB) bCnt <= bCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modSel     <= 2'd0;
      cfgIllegal <= 1'b0;
      ratioLow   <= 1'b0;
    end else if (strobe.load) begin
      modSel     <= selEff;
      cfgIllegal <= illegal;
      ratioLow   <= low;
    end
  end

  assign aZero   = (aCnt == '0);
  assign bZero   = (bCnt == '0);
  assign modCtrl = !aZero;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     presSel,
  input  logic [A_W-1:0] swallowIn,
  input  logic [B_W-1:0] mainIn,
  output logic           modCtrl,
  output logic           fbPulse,
  output logic [1:0]     modSel,
  output logic           cfgIllegal,
  output logic           ratioLow
);
  import psw_pkg::*;

  ctlStrobe_t     strobe;
  logic [1:0]     selEff;
  logic [A_W-1:0] aEff;
  logic [B_W-1:0] bEff;
  logic           illegal;
  logic           low;
  logic           aZero;
  logic           bZero;

  psw_cfg #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cfg (
    .selIn(presSel), .aIn(swallowIn), .bIn(mainIn),
    .selEff(selEff), .aEff(aEff), .bEff(bEff),
    .illegal(illegal), .low(low)
  );

  psw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .aZero(aZero), .bZero(bZero),
    .strobe(strobe), .fbPulse(fbPulse)
  );

  psw_datapath #(.A_W(A_W), .B_W(B_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .selEff(selEff), .aEff(aEff), .bEff(bEff),
    .illegal(illegal), .low(low),
    .aZero(aZero), .bZero(bZero), .modCtrl(modCtrl),
    .modSel(modSel), .cfgIllegal(cfgIllegal), .ratioLow(ratioLow)
  );

endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modCtrl,
  input logic       fbPulse,
  input logic [1:0] modSel,
  input logic       cfgIllegal,
  input logic       ratioLow
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse);

  // R3
  pulse_mod_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |-> !modCtrl);

  // R3
  mod_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(modCtrl) && cyc >= 2'd2) |-> $past(fbPulse));

  // R5
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && !$past(fbPulse)) |->
      ($stable(modSel) && $stable(cfgIllegal) && $stable(ratioLow)));

  // R4
  sel_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    modSel != 2'd3);

endmodule

bind pulse_swallow_div pulse_swallow_div_chk u_chk (
  .clk(clk), .rstN(rstN), .modCtrl(modCtrl), .fbPulse(fbPulse),
  .modSel(modSel), .cfgIllegal(cfgIllegal), .ratioLow(ratioLow)
);

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
  localparam int CLK_P = 10;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  presSel = 2'd0;
  logic [4:0]  swallowIn = 5'd0;
  logic [12:0] mainIn = 13'd0;
  logic        modCtrl, fbPulse, cfgIllegal, ratioLow;
  logic [1:0]  modSel;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pulse_swallow_div u0 (
    .clk(clk), .rstN(rstN), .presSel(presSel), .swallowIn(swallowIn),
    .mainIn(mainIn), .modCtrl(modCtrl), .fbPulse(fbPulse), .modSel(modSel),
    .cfgIllegal(cfgIllegal), .ratioLow(ratioLow)
  );

  function automatic int effB(int b); return (b < 3) ? 3 : b; endfunction
  function automatic int effA(int a, int b);
    return (a >= effB(b)) ? effB(b) - 1 : a;
  endfunction
  function automatic int selN(int s); return (s == 3) ? 2 : s; endfunction
  function automatic int pOf(int s); return 8 << selN(s); endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (frame %0d)", tag, act, exp, frames);
    end
  endtask

  // Monitor with behavioural prescaler
  int curA, curB, curS;
  int len, highs, vco;
  bit needLoad = 1;
  bit resetSeen = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      needLoad = 1;
      if (!resetSeen) begin
        resetSeen = 1;
        chk(int'(modCtrl), 0, "R9 modCtrl in reset");
        chk(int'(fbPulse), 0, "R9 fbPulse in reset");
        chk(int'(modSel), 0, "R9 modSel in reset");
        chk(int'(cfgIllegal) + int'(ratioLow), 0, "R9 flags in reset");
      end
    end else if (needLoad) begin
      needLoad = 0;
      chk(int'(fbPulse) + int'(modCtrl), 0, "R9 idle cycle before first load");
      curA = swallowIn; curB = mainIn; curS = presSel;
      len = 0; highs = 0; vco = 0;
    end else begin
      int p, eA, eB, n;
      p = pOf(curS);
      len++;
      highs += modCtrl ? 1 : 0;
      vco += modCtrl ? p + 1 : p;
      if (fbPulse) begin
        eB = effB(curB); eA = effA(curA, curB); n = eB * p + eA;
        chk(len, eB, "R2 frame length");
        chk(highs, eA, (curA == 0) ? "R10 swallow cycles" : "R3 swallow cycles");
        chk(vco, n, "R1 division ratio");
        chk(int'(modSel), selN(curS), "R4 modulus code");
        chk(int'(cfgIllegal), (curB < 3 || curA >= effB(curB)) ? 1 : 0,
            (curB < 3) ? "R7 illegal flag" : "R6 illegal flag");
        chk(int'(ratioLow), (n < p * p - p) ? 1 : 0, "R8 low-ratio flag");
        frames++;
        curA = swallowIn; curB = mainIn; curS = presSel;
        len = 0; highs = 0; vco = 0;
      end
    end
  end

  task automatic setCfg(int a, int b, int s);
    @(posedge clk); #2;
    swallowIn = 5'(a); mainIn = 13'(b); presSel = 2'(s);
  endtask

  task automatic holdFrames(int n);
    int target;
    target = frames + n;
    while (frames < target) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    swallowIn = 5'd5; mainIn = 13'd10; presSel = 2'd0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    holdFrames(2);
    setCfg(0, 7, 1);     holdFrames(2);  // R10
    setCfg(31, 31, 2);   holdFrames(2);  // R6 A equal to B
    setCfg(2, 1, 0);     holdFrames(2);  // R7 B below minimum
    setCfg(2, 3, 0);     holdFrames(2);  // R8 ratio below P^2-P
    setCfg(4, 20, 3);    holdFrames(2);  // R4 reserved code
    setCfg(31, 8191, 2); holdFrames(2);  // R1 largest main count
    setCfg(7, 40, 1);    holdFrames(2);
    // R5: random values changed mid-frame
    for (int i = 0; i < 120; i++) begin
      setCfg($urandom % 32, $urandom % 64, $urandom % 4);
      repeat ($urandom % 50 + 1) @(posedge clk);
    end
    holdFrames(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * LIMIT);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d frames, expected run to complete", frames);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule